// File: doc/BRIEF.md
# Interrupt Enable and Status Controller

This block holds the interrupt registers of a security-module host interface. Four one-cycle event pulses come in from the neighbouring logic: data available, status valid, locality changed and command ready. Each pulse sets a sticky status bit. Software reads those bits and clears them by writing ones. A per-source enable mask, together with a master enable at bit 31, decides which pending sources reach the single interrupt line.

The line is registered. Two parameters fix its behaviour. The first selects level signalling (the line follows the gated request) or edge signalling (a one-cycle pulse each time the gated request newly rises). The second selects active-high or active-low polarity. A read-only capability word reports the chosen signalling variant, the supported sources and whether the burst count is static. A byte-wide vector register stores the interrupt line number that software chooses. The register bus is a plain 32-bit read/write port. Read data is registered.

Top module: `irq_ctrl`

## Requirements
- R1: After a synchronous reset, the enable, status and vector registers read 0 and the interrupt line is at its inactive level.
- R2: An event pulse sets its status bit on the next clock edge whatever the enable bits hold. The bit positions are: data available bit 0, status valid bit 1, locality change bit 2, command ready bit 7.
- R3: A write to the status register (offset 0x10) clears exactly the bits that are 1 in the written word. An event arriving in the same cycle as a clear of its bit leaves the bit set.
- R4: While enable bit 31 is 0, the interrupt line stays inactive, even when enabled sources are pending.
- R5: In level mode, the line goes active one cycle after the OR of (status AND enable) becomes true with bit 31 set. It stays active until that term falls.
- R6: In edge mode, each new rising of the gated request produces exactly one active cycle on the line.
- R7: A polarity parameter selects active-high (inactive 0) or active-low (inactive 1) signalling.
- R8: The vector register (offset 0x0C) stores bits 7:0 of a write. It reads back with bits 31:8 as zero.
- R9: The enable register (offset 0x08) keeps only bits 31, 7, 2, 1 and 0. All other bits read 0.
- R10: The capability register (offset 0x14) is read-only. Bits 0, 1, 2 and 7 are 1. Exactly one of the following is 1, matching the configuration: bit 3 (level high), bit 4 (level low), bit 5 (rising edge) or bit 6 (falling edge). Bit 8 reports a static burst count.
- R11: A read of any other offset returns 0.
- R12: Read data appears on the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| ev_data_avail | input | 1 | Data available event pulse |
| ev_sts_valid | input | 1 | Status valid event pulse |
| ev_loc_change | input | 1 | Locality change event pulse |
| ev_cmd_ready | input | 1 | Command ready event pulse |
| irq | output | 1 | Interrupt line in the configured mode and polarity |

## Verification
The hardest case to reach is the collision: an event pulse lands in the very cycle in which software writes a one to clear the same status bit. The write task therefore accepts an event vector and drives it together with the bus strobe. The status read and the interrupt line then show that the set won. In edge mode, the second hard case is a fresh pulse produced with no new event: sources stay pending while the master enable drops and rises again, or while only the enable mask changes.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned DW = 32;
  localparam logic [7:0] OFF_ENABLE = 8'h08;
  localparam logic [7:0] OFF_VECTOR = 8'h0C;
  localparam logic [7:0] OFF_STATUS = 8'h10;
  localparam logic [7:0] OFF_CAPS   = 8'h14;
  localparam int unsigned BIT_DAV = 0;
  localparam int unsigned BIT_SVL = 1;
  localparam int unsigned BIT_LOC = 2;
  localparam int unsigned BIT_CRD = 7;
  localparam int unsigned BIT_GLB = 31;
  localparam logic [DW-1:0] SRC_MASK = (32'd1 << BIT_DAV) | (32'd1 << BIT_SVL) |
                                       (32'd1 << BIT_LOC) | (32'd1 << BIT_CRD);
  localparam logic [DW-1:0] EN_MASK  = SRC_MASK | (32'd1 << BIT_GLB);

  function automatic logic [DW-1:0] caps_word(input bit edge_mode, input bit act_low,
                                             input bit burst_static);
    logic [DW-1:0] w;
    w = SRC_MASK;
    w[3 + {edge_mode, act_low}] = 1'b1;
    w[8] = burst_static;
    return w;
  endfunction
endpackage

// File: rtl/irq_status.sv
module irq_status
  import irq_ctrl_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] ev_vec,
  input  logic          clr_wr,
  input  logic [DW-1:0] clr_data,
  output logic [DW-1:0] sts_q
);
  logic [DW-1:0] ev_m;
  logic [DW-1:0] clr_m;

  assign ev_m  = ev_vec & SRC_MASK;
  assign clr_m = clr_wr ? (clr_data & SRC_MASK) : '0;

  always_ff @(posedge clk) begin
    if (rst) sts_q <= '0;
    else     sts_q <= (sts_q & ~clr_m) | ev_m;
  end

  assert_latch_R2: assert property (@(posedge clk) disable iff (rst)
    (ev_m != '0) |=> ((sts_q & $past(ev_m)) == $past(ev_m)));
  assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> ((sts_q & $past(clr_data & SRC_MASK & ~ev_m)) == '0));
  assert_only_src_R2: assert property (@(posedge clk) disable iff (rst)
    (sts_q & ~SRC_MASK) == '0);
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter bit          EDGE_MODE    = 1'b0,
  parameter bit          ACTIVE_LOW   = 1'b0,
  parameter bit          BURST_STATIC = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_rd,
  input  logic [DW-1:0]     sts_q,
  output logic              sts_wr,
  output logic [DW-1:0]     en_q,
  output logic [DW-1:0]     bus_rdata
);
  localparam logic [DW-1:0] CAPS = caps_word(EDGE_MODE, ACTIVE_LOW, BURST_STATIC);
  localparam int unsigned   VW   = 8;

  logic [VW-1:0] vec_q;
  logic          sel_en, sel_vec, sel_sts, sel_cap;
  logic [DW-1:0] rd_mux;

  assign sel_en  = bus_addr == ADDR_W'(OFF_ENABLE);
  assign sel_vec = bus_addr == ADDR_W'(OFF_VECTOR);
  assign sel_sts = bus_addr == ADDR_W'(OFF_STATUS);
  assign sel_cap = bus_addr == ADDR_W'(OFF_CAPS);
  assign sts_wr  = bus_wr && sel_sts;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      vec_q <= '0;
    end else if (bus_wr) begin
      if (sel_en)  en_q  <= bus_wdata & EN_MASK;
      if (sel_vec) vec_q <= bus_wdata[VW-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel_en)  rd_mux = en_q;
    if (sel_vec) rd_mux = {{(DW-VW){1'b0}}, vec_q};
    if (sel_sts) rd_mux = sts_q;
    if (sel_cap) rd_mux = CAPS;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assert_vector_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel_vec) |=> (vec_q == $past(bus_wdata[VW-1:0])));
  assert_en_bits_R9: assert property (@(posedge clk) disable iff (rst)
    (en_q & ~EN_MASK) == '0);
  assert_rd_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: rtl/irq_out.sv
module irq_out #(
  parameter bit EDGE_MODE  = 1'b0,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic act_q,
  output logic irq
);
  generate
    if (EDGE_MODE) begin : g_edge
      logic req_d;
      always_ff @(posedge clk) begin
        if (rst) begin
          req_d <= 1'b0;
          act_q <= 1'b0;
        end else begin
          req_d <= req;
          act_q <= req && !req_d;
        end
      end
      assert_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        act_q |=> !act_q);
    end else begin : g_level
      always_ff @(posedge clk) begin
        if (rst) act_q <= 1'b0;
        else     act_q <= req;
      end
      assert_follow_R5: assert property (@(posedge clk) disable iff (rst)
        req |=> act_q);
    end
  endgenerate

  assign irq = act_q ^ ACTIVE_LOW;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter bit          EDGE_MODE    = 1'b0,
  parameter bit          ACTIVE_LOW   = 1'b0,
  parameter bit          BURST_STATIC = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic              ev_data_avail,
  input  logic              ev_sts_valid,
  input  logic              ev_loc_change,
  input  logic              ev_cmd_ready,
  output logic              irq
);
  logic [DW-1:0] ev_vec, sts_q, en_q;
  logic          sts_wr, req, act_q;

  always_comb begin
    ev_vec          = '0;
    ev_vec[BIT_DAV] = ev_data_avail;
    ev_vec[BIT_SVL] = ev_sts_valid;
    ev_vec[BIT_LOC] = ev_loc_change;
    ev_vec[BIT_CRD] = ev_cmd_ready;
  end

  irq_regs #(.ADDR_W(ADDR_W), .EDGE_MODE(EDGE_MODE), .ACTIVE_LOW(ACTIVE_LOW),
             .BURST_STATIC(BURST_STATIC)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .sts_q(sts_q), .sts_wr(sts_wr),
    .en_q(en_q), .bus_rdata(bus_rdata));

  irq_status u_sts (
    .clk(clk), .rst(rst), .ev_vec(ev_vec), .clr_wr(sts_wr),
    .clr_data(bus_wdata), .sts_q(sts_q));

  assign req = en_q[BIT_GLB] && ((sts_q & en_q & SRC_MASK) != '0);

  irq_out #(.EDGE_MODE(EDGE_MODE), .ACTIVE_LOW(ACTIVE_LOW)) u_out (
    .clk(clk), .rst(rst), .req(req), .act_q(act_q), .irq(irq));

  assert_global_gate_R4: assert property (@(posedge clk) disable iff (rst)
    !en_q[BIT_GLB] |=> !act_q);
  assert_polarity_R7: assert property (@(posedge clk) disable iff (rst)
    !act_q |-> (irq == ACTIVE_LOW));
endmodule

// File: tb/tb_irq_ctrl.sv
module tb_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  ev = '0;
  logic [31:0] rdata_a, rdata_b;
  logic        irq_a, irq_b;
  int          checks = 0, failures = 0;
  bit          done = 1'b0;

  typedef struct { logic [31:0] exp_a; logic [31:0] exp_b; string tag; } item_t;
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  irq_ctrl #(.EDGE_MODE(1'b0), .ACTIVE_LOW(1'b0)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(rdata_a), .ev_data_avail(ev[0]), .ev_sts_valid(ev[1]),
    .ev_loc_change(ev[2]), .ev_cmd_ready(ev[3]), .irq(irq_a));

  irq_ctrl #(.EDGE_MODE(1'b1), .ACTIVE_LOW(1'b1)) dut_edge (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(rdata_b), .ev_data_avail(ev[0]), .ev_sts_valid(ev[1]),
    .ev_loc_change(ev[2]), .ev_cmd_ready(ev[3]), .irq(irq_b));

  // Monitor: pops one expected item per read strobe, once the registered data has settled (R12)
  always @(posedge clk) begin
    if (bus_rd && !rst) begin
      #1;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R12 read with no expected item");
      end else begin
        item_t it;
        it = exp_q.pop_front();
        checks++;
        if (rdata_a !== it.exp_a || rdata_b !== it.exp_b) begin
          failures++;
          $display("FAIL %s actual=%h/%h expected=%h/%h", it.tag, rdata_a, rdata_b,
                   it.exp_a, it.exp_b);
        end
      end
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] ea, input logic [31:0] eb,
                    input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    it.exp_a = ea; it.exp_b = eb; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] evv);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; ev = evv;
    @(negedge clk);
    bus_wr = 1'b0; ev = '0;
  endtask

  task automatic pulse(input logic [3:0] evv);
    @(negedge clk);
    ev = evv;
    @(negedge clk);
    ev = '0;
  endtask

  task automatic chk_irq(input logic ea, input logic eb, input string tag);
    checks++;
    if (irq_a !== ea || irq_b !== eb) begin
      failures++;
      $display("FAIL %s irq actual=%b/%b expected=%b/%b", tag, irq_a, irq_b, ea, eb);
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk_irq(1'b0, 1'b1, "R1 reset level");
    rd(8'h08, 32'h0, 32'h0, "R1 enable after reset");
    rd(8'h10, 32'h0, 32'h0, "R1 status after reset");
    rd(8'h0C, 32'h0, 32'h0, "R1 vector after reset");
    rd(8'h14, 32'h18F, 32'h1C7, "R10 capability word");

    pulse(4'b0001);
    @(negedge clk);
    chk_irq(1'b0, 1'b1, "R2 latch with no enable");
    rd(8'h10, 32'h1, 32'h1, "R2 data-available latched");

    wr(8'h08, 32'h0000_0001, 4'b0);
    @(negedge clk);
    chk_irq(1'b0, 1'b1, "R4 global gate clear");
    wr(8'h08, 32'h8000_0001, 4'b0);
    @(negedge clk);
    chk_irq(1'b1, 1'b0, "R5 R6 R7 line active");
    @(negedge clk);
    chk_irq(1'b1, 1'b1, "R6 edge pulse one cycle, R5 level held");
    rd(8'h08, 32'h8000_0001, 32'h8000_0001, "R9 enable readback");
    wr(8'h08, 32'hFFFF_FFFF, 4'b0);
    rd(8'h08, 32'h8000_0087, 32'h8000_0087, "R9 unused enable bits");

    wr(8'h10, 32'h0, 4'b0);
    rd(8'h10, 32'h1, 32'h1, "R3 zero write keeps status");
    wr(8'h10, 32'h2, 4'b0);
    rd(8'h10, 32'h1, 32'h1, "R3 other bit write keeps status");
    wr(8'h10, 32'h1, 4'b0);
    @(negedge clk);
    chk_irq(1'b0, 1'b1, "R3 R5 clear drops line");
    rd(8'h10, 32'h0, 32'h0, "R3 bit cleared");

    wr(8'h10, 32'h2, 4'b0010);
    @(negedge clk);
    chk_irq(1'b1, 1'b0, "R3 set wins over clear");
    rd(8'h10, 32'h2, 32'h2, "R3 collision status");
    wr(8'h10, 32'hFFFF_FFFF, 4'b0);
    rd(8'h10, 32'h0, 32'h0, "R3 clear all");

    pulse(4'b1111);
    rd(8'h10, 32'h87, 32'h87, "R2 all four sources");
    wr(8'h10, 32'h4, 4'b0);
    rd(8'h10, 32'h83, 32'h83, "R3 clear locality only");
    wr(8'h08, 32'h0000_0087, 4'b0);
    @(negedge clk);
    chk_irq(1'b0, 1'b1, "R4 master off with pending");
    wr(8'h08, 32'h8000_0080, 4'b0);
    @(negedge clk);
    chk_irq(1'b1, 1'b0, "R6 new rise after re-enable");
    @(negedge clk);
    chk_irq(1'b1, 1'b1, "R5 R6 after re-enable");

    wr(8'h0C, 32'hABCD_1234, 4'b0);
    rd(8'h0C, 32'h34, 32'h34, "R8 vector byte");
    wr(8'h14, 32'h0, 4'b0);
    rd(8'h14, 32'h18F, 32'h1C7, "R10 capability write ignored");
    rd(8'h00, 32'h0, 32'h0, "R11 unmapped offset 0x00");
    rd(8'h18, 32'h0, 32'h0, "R11 unmapped offset 0x18");
    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R12 reads left unanswered actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule